// File: doc/BRIEF.md
# Selectable-Length PRBS Self-Test Engine

This block is a self-test engine for a serial data path. It has two independent halves. The transmit half produces a pseudo-random bit stream from a linear feedback shift register of 9 or 15 stages. The receive half runs its own register of the same length. It first locks that register to the incoming stream, then compares every later bit with the value it predicts. The stream may be fed back to the receive half directly or through an external cable path. A single control write starts or stops a test. That write also captures the sequence length and resets the result.

The result is given as two outputs. The first is a pass flag. It rises only after one full sequence period has been compared with no error. Once any mis-compare occurs, the flag stays low until the next control write. The second is a saturating count of mis-compared bits. Without the continuous-mode enable, the transmit half sends one lock preamble plus one full period and then goes quiet. With the enable set, it keeps sending until a stop write arrives.

Top module: `prbs_bist`

## Requirements
- R1: After reset, tx_valid is 0, bist_pass is 0 and err_count is 0.
- R2: With state s (all ones on start), each sent bit is b = s[L-1] xor s[T-1], and the next state is {s[L-2:0], b}. The pair (L,T) is (9,5) when the captured select is 0 and (15,14) when it is 1. The first bit is on tx_bit in the cycle after the start write.
- R3: sel_long is sampled only on a control write. Changing it during a test does not alter the sequence or the verdict.
- R4: With cont_en low, the transmitter sends exactly L + 2^L - 1 bits and then drops tx_valid.
- R5: With cont_en high, the transmitter keeps tx_valid high past that length, until a stop write.
- R6: A control write with ctl_run = 0 drops tx_valid in the following cycle.
- R7: The checker shifts the first L valid received bits into its register without comparing them. After that it compares each valid bit and advances with its own predicted bit. As a result, each flipped bit counts exactly one error.
- R8: bist_pass stays 0 until 2^L - 1 bits have been compared with no error. It becomes 1 in the cycle after the last of those compares.
- R9: Any mis-compare forces bist_pass to 0, and it stays 0 until the next control write, however many good bits follow.
- R10: err_count counts mis-compares and saturates at 255.
- R11: Every control write, whether start or stop, clears err_count and bist_pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | One-cycle write strobe of the start/stop control |
| ctl_run | input | 1 | Value written: 1 starts a test, 0 stops it |
| sel_long | input | 1 | Length select: 0 for 9 stages, 1 for 15 stages; captured on ctl_wr |
| cont_en | input | 1 | Keep transmitting past one preamble plus period |
| rx_bit | input | 1 | Received test bit |
| rx_valid | input | 1 | rx_bit carries a bit this cycle |
| tx_bit | output | 1 | Generated test bit |
| tx_valid | output | 1 | tx_bit carries a bit this cycle |
| bist_pass | output | 1 | 1 once a full error-free period has been compared |
| err_count | output | 8 | Saturating count of mis-compared bits |

## Verification
A generator register that has drifted or carries the wrong tap shows on tx_bit at the first wrong bit. It is caught in that same cycle by comparison against an arithmetic model. A checker register that has lost lock shows as err_count climbing on nearly every following bit. A faulty pass or failure latch shows only at the end of a period: as a pass flag that rises one bit early, fails to rise, or rises again after an error. The bench therefore samples bist_pass on both sides of the last compare, and sweeps the number of flipped bits across the saturation point of the counter.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
   typedef enum logic {
      PRBS_SHORT = 1'b0,
      PRBS_LONG  = 1'b1
   } prbs_len_e;
endpackage

// File: rtl/prbs_fb.sv
module prbs_fb
   import prbs_pkg::*;
#(
   parameter int LONG_LEN  = 15,
   parameter int LONG_TAP  = 14,
   parameter int SHORT_LEN = 9,
   parameter int SHORT_TAP = 5
) (
   input  logic [LONG_LEN-1:0] state,
   input  prbs_len_e           mode,
   output logic                fb
);
   // Tap masks: polynomial x^L + x^T + 1 reads stages L-1 and T-1.
   localparam logic [LONG_LEN-1:0] MASK_L =
      LONG_LEN'((1 << (LONG_LEN-1)) | (1 << (LONG_TAP-1)));
   localparam logic [LONG_LEN-1:0] MASK_S =
      LONG_LEN'((1 << (SHORT_LEN-1)) | (1 << (SHORT_TAP-1)));

   logic [LONG_LEN-1:0] mask;

   always_comb begin
      mask = (mode == PRBS_LONG) ? MASK_L : MASK_S;
      fb   = ^(state & mask);
   end
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
   import prbs_pkg::*;
#(
   parameter int LONG_LEN  = 15,
   parameter int LONG_TAP  = 14,
   parameter int SHORT_LEN = 9,
   parameter int SHORT_TAP = 5
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr,
   input  logic      wr_val,
   input  prbs_len_e mode,
   input  logic      cont_en,
   output logic      tx_bit,
   output logic      tx_valid
);
   localparam int CNT_W = LONG_LEN + 1;
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SHORT_LEN + (1 << SHORT_LEN) - 2);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LONG_LEN + (1 << LONG_LEN) - 2);

   logic [LONG_LEN-1:0] lf;
   logic                run_q;
   logic [CNT_W-1:0]    cnt;
   logic [CNT_W-1:0]    last_idx;
   logic                fb;

   prbs_fb #(
      .LONG_LEN (LONG_LEN),  .LONG_TAP (LONG_TAP),
      .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP)
   ) i_fb (
      .state(lf), .mode(mode), .fb(fb)
   );

   assign last_idx = (mode == PRBS_LONG) ? LAST_L : LAST_S;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lf    <= '1;
         run_q <= 1'b0;
         cnt   <= '0;
      end else if (wr) begin
         lf    <= '1;
         run_q <= wr_val;
         cnt   <= '0;
      end else if (run_q) begin
         lf <= {lf[LONG_LEN-2:0], fb};
         if (cnt != last_idx) cnt <= cnt + 1'b1;
         else if (!cont_en)   run_q <= 1'b0;
      end
   end

   assign tx_valid = run_q;
   assign tx_bit   = run_q & fb;

   // R6: a stop write silences the transmitter on the next cycle
   a_r6_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wr_val) |=> !tx_valid);
   // R5: continuous mode never ends a run on its own
   a_r5_cont_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && cont_en && !wr) |=> tx_valid);
   // R2: a start write always yields output on the next cycle
   a_r2_start_emits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wr_val) |=> tx_valid);
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
   import prbs_pkg::*;
#(
   parameter int LONG_LEN  = 15,
   parameter int LONG_TAP  = 14,
   parameter int SHORT_LEN = 9,
   parameter int SHORT_TAP = 5,
   parameter int ERR_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             wr_val,
   input  prbs_len_e        mode,
   input  logic             rx_bit,
   input  logic             rx_valid,
   output logic             pass,
   output logic [ERR_W-1:0] err_cnt
);
   localparam int SYNC_W = $clog2(LONG_LEN + 1);
   localparam logic [LONG_LEN-1:0] PER_S   = LONG_LEN'((1 << SHORT_LEN) - 1);
   localparam logic [LONG_LEN-1:0] PER_L   = LONG_LEN'((1 << LONG_LEN) - 1);
   localparam logic [ERR_W-1:0]    ERR_MAX = '1;

   logic [LONG_LEN-1:0] st;
   logic                act_q;
   logic [SYNC_W-1:0]   sync_cnt;
   logic [LONG_LEN-1:0] cmp_cnt;
   logic                failed_q;
   logic                pass_q;
   logic [ERR_W-1:0]    err_q;
   logic                exp_bit;
   logic                locked;
   logic                miss;
   logic [SYNC_W-1:0]   sync_len;
   logic [LONG_LEN-1:0] period;

   prbs_fb #(
      .LONG_LEN (LONG_LEN),  .LONG_TAP (LONG_TAP),
      .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP)
   ) i_fb (
      .state(st), .mode(mode), .fb(exp_bit)
   );

   always_comb begin
      sync_len = (mode == PRBS_LONG) ? SYNC_W'(LONG_LEN) : SYNC_W'(SHORT_LEN);
      period   = (mode == PRBS_LONG) ? PER_L : PER_S;
      locked   = (sync_cnt == sync_len);
      miss     = act_q && rx_valid && locked && (rx_bit != exp_bit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= '0;
         act_q    <= 1'b0;
         sync_cnt <= '0;
         cmp_cnt  <= '0;
         failed_q <= 1'b0;
         pass_q   <= 1'b0;
         err_q    <= '0;
      end else if (wr) begin
         st       <= '0;
         act_q    <= wr_val;
         sync_cnt <= '0;
         cmp_cnt  <= '0;
         failed_q <= 1'b0;
         pass_q   <= 1'b0;
         err_q    <= '0;
      end else if (act_q && rx_valid) begin
         if (!locked) begin
            st       <= {st[LONG_LEN-2:0], rx_bit};
            sync_cnt <= sync_cnt + 1'b1;
         end else begin
            st <= {st[LONG_LEN-2:0], exp_bit};
            if (cmp_cnt != period) cmp_cnt <= cmp_cnt + 1'b1;
            if (miss) begin
               failed_q <= 1'b1;
               pass_q   <= 1'b0;
               if (err_q != ERR_MAX) err_q <= err_q + 1'b1;
            end else if (!failed_q && cmp_cnt == period - 1'b1) begin
               pass_q <= 1'b1;
            end
         end
      end
   end

   assign pass    = pass_q;
   assign err_cnt = err_q;

   // R9: a recorded failure holds, and pass stays low, until a write
   a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (failed_q && !wr) |=> (failed_q && !pass));
   // R10: the counter holds at its ceiling
   a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt == ERR_MAX && !wr) |=> err_cnt == ERR_MAX);
   // R10: the counter moves by at most one per cycle
   a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));
   // R11: any control write clears the verdict and the count
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (err_cnt == '0 && !pass));
   // R8: pass is only reached through a completed error-free period
   a_r8_pass_needs_period: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> (cmp_cnt == period && !failed_q));
endmodule

// File: rtl/prbs_bist.sv
module prbs_bist
   import prbs_pkg::*;
#(
   parameter int LONG_LEN  = 15,
   parameter int LONG_TAP  = 14,
   parameter int SHORT_LEN = 9,
   parameter int SHORT_TAP = 5,
   parameter int ERR_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_run,
   input  logic             sel_long,
   input  logic             cont_en,
   input  logic             rx_bit,
   input  logic             rx_valid,
   output logic             tx_bit,
   output logic             tx_valid,
   output logic             bist_pass,
   output logic [ERR_W-1:0] err_count
);
   initial begin
      a_cfg_lengths: assert (SHORT_LEN >= 3 && SHORT_LEN < LONG_LEN && LONG_LEN <= 24)
         else $error("prbs_bist: unsupported register lengths");
      a_cfg_taps: assert (SHORT_TAP > 0 && SHORT_TAP < SHORT_LEN &&
                          LONG_TAP > 0 && LONG_TAP < LONG_LEN)
         else $error("prbs_bist: tap outside register");
      a_cfg_err_w: assert (ERR_W >= 1 && ERR_W <= 16)
         else $error("prbs_bist: bad error counter width");
   end

   prbs_len_e mode_q;

   // R3: length is captured once per control write
   always_ff @(posedge clk) begin
      if (!rst_n)      mode_q <= PRBS_SHORT;
      else if (ctl_wr) mode_q <= sel_long ? PRBS_LONG : PRBS_SHORT;
   end

   prbs_gen #(
      .LONG_LEN (LONG_LEN),  .LONG_TAP (LONG_TAP),
      .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP)
   ) i_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ctl_wr),
      .wr_val  (ctl_run),
      .mode    (mode_q),
      .cont_en (cont_en),
      .tx_bit  (tx_bit),
      .tx_valid(tx_valid)
   );

   prbs_chk #(
      .LONG_LEN (LONG_LEN),  .LONG_TAP (LONG_TAP),
      .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP),
      .ERR_W    (ERR_W)
   ) i_chk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ctl_wr),
      .wr_val  (ctl_run),
      .mode    (mode_q),
      .rx_bit  (rx_bit),
      .rx_valid(rx_valid),
      .pass    (bist_pass),
      .err_cnt (err_count)
   );

   // R3: the captured length cannot move while no write occurs
   a_r3_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(mode_q));
endmodule

// File: tb/test_prbs_bist.sv
module test_prbs_bist;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, ctl_run = 1'b0, sel_long = 1'b0, cont_en = 1'b0;
   logic inj = 1'b0;
   logic rx_bit, rx_valid, tx_bit, tx_valid, bist_pass;
   logic [7:0] err_count;

   int n_chk = 0;
   int n_fail = 0;
   int inj_lo = 0, inj_hi = 0;
   logic [14:0] ms = '1;
   logic mlong = 1'b0;

   always #2 clk = ~clk;

   // External loopback with optional bit flips
   assign rx_bit   = tx_bit ^ inj;
   assign rx_valid = tx_valid;

   prbs_bist i_prbs_bist (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
      .sel_long(sel_long), .cont_en(cont_en), .rx_bit(rx_bit), .rx_valid(rx_valid),
      .tx_bit(tx_bit), .tx_valid(tx_valid), .bist_pass(bist_pass), .err_count(err_count)
   );

   function automatic logic mbit(logic [14:0] s, logic lng);
      return lng ? (s[14] ^ s[13]) : (s[8] ^ s[4]);
   endfunction

   task automatic chk(input string req, input logic ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ctl(input logic run, input logic lng, input logic cont);
      @(negedge clk);
      sel_long = lng; cont_en = cont; ctl_run = run; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
      ms = '1; mlong = lng;
   endtask

   task automatic run_bits(input int n, output int mism, output logic st_last);
      mism = 0; st_last = 1'b0;
      for (int b = 0; b < n; b++) begin
         inj = (b >= inj_lo && b < inj_hi);
         if (!tx_valid || tx_bit !== mbit(ms, mlong)) mism++;
         if (b == n - 1) st_last = bist_pass;
         ms = {ms[13:0], mbit(ms, mlong)};
         @(negedge clk);
      end
      inj = 1'b0;
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int mism;
      logic st_last;
      int ks [9] = '{1, 2, 3, 7, 100, 254, 255, 256, 300};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tx_valid", tx_valid === 1'b0, tx_valid, 0);
      chk("R1 bist_pass", bist_pass === 1'b0, bist_pass, 0);
      chk("R1 err_count", err_count === 8'd0, err_count, 0);

      // Short sequence, single burst
      ctl(1'b1, 1'b0, 1'b0);
      run_bits(520, mism, st_last);
      chk("R2 short sequence", mism == 0, mism, 0);
      chk("R8 no pass before last compare", st_last === 1'b0, st_last, 0);
      chk("R4 short burst ends", tx_valid === 1'b0, tx_valid, 0);
      chk("R8 pass after short period", bist_pass === 1'b1, bist_pass, 1);
      chk("R7 clean loop no errors", err_count === 8'd0, err_count, 0);
      repeat (5) @(negedge clk);
      chk("R8 pass holds while idle", bist_pass === 1'b1, bist_pass, 1);

      // Long sequence, single burst
      ctl(1'b1, 1'b1, 1'b0);
      run_bits(32782, mism, st_last);
      chk("R2 long sequence", mism == 0, mism, 0);
      chk("R8 long no early pass", st_last === 1'b0, st_last, 0);
      chk("R4 long burst ends", tx_valid === 1'b0, tx_valid, 0);
      chk("R8 pass after long period", bist_pass === 1'b1, bist_pass, 1);

      // R3: select toggled after the start write is ignored
      ctl(1'b1, 1'b0, 1'b0);
      sel_long = 1'b1;
      run_bits(520, mism, st_last);
      chk("R3 sequence unchanged by select", mism == 0, mism, 0);
      chk("R3 verdict unchanged by select", bist_pass === 1'b1, bist_pass, 1);
      chk("R3 burst length unchanged", tx_valid === 1'b0, tx_valid, 0);

      // R7/R9/R5: one flipped bit in continuous mode
      inj_lo = 100; inj_hi = 101;
      ctl(1'b1, 1'b0, 1'b1);
      run_bits(1100, mism, st_last);
      chk("R7 single flip counts one", err_count === 8'd1, err_count, 1);
      chk("R9 fail sticky after later periods", bist_pass === 1'b0, bist_pass, 0);
      chk("R5 continuous still sending", tx_valid === 1'b1, tx_valid, 1);
      chk("R2 continuous sequence", mism == 0, mism, 0);

      // R6/R11: stop write
      ctl(1'b0, 1'b0, 1'b1);
      chk("R6 stop drops tx_valid", tx_valid === 1'b0, tx_valid, 0);
      chk("R11 stop clears count", err_count === 8'd0, err_count, 0);
      chk("R11 stop clears pass", bist_pass === 1'b0, bist_pass, 0);

      // R10 sweep of flip counts across saturation
      foreach (ks[i]) begin
         inj_lo = 20; inj_hi = 20 + ks[i];
         ctl(1'b1, 1'b0, 1'b1);
         run_bits(ks[i] + 25, mism, st_last);
         chk($sformatf("R10 count after %0d flips", ks[i]),
             err_count == ((ks[i] > 255) ? 255 : ks[i]), err_count,
             (ks[i] > 255) ? 255 : ks[i]);
         chk("R9 pass low after flips", bist_pass === 1'b0, bist_pass, 0);
      end

      // R11: restart after saturation clears and a clean period passes again
      inj_lo = 0; inj_hi = 0;
      ctl(1'b1, 1'b0, 1'b1);
      chk("R11 start clears count", err_count === 8'd0, err_count, 0);
      run_bits(520, mism, st_last);
      chk("R8 pass after restart", bist_pass === 1'b1, bist_pass, 1);
      chk("R5 still sending past burst length", tx_valid === 1'b1, tx_valid, 1);

      // Long mode flips
      inj_lo = 40; inj_hi = 43;
      ctl(1'b1, 1'b1, 1'b1);
      run_bits(60, mism, st_last);
      chk("R7 long three flips", err_count === 8'd3, err_count, 3);
      chk("R2 long continuous sequence", mism == 0, mism, 0);
      inj_lo = 0; inj_hi = 0;
      ctl(1'b0, 1'b1, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule